// File: doc/BRIEF.md
# Memory-Bit Conditional Branch Sequencer

This block executes one three-byte instruction of an 8-bit processor: "branch if a chosen bit of a direct-page byte is 1". A single-cycle start pulse hands it the instruction's address and the direct-page select flag. It then fetches the opcode, the page index and the signed displacement over a byte-wide read port and reads the addressed byte. From that byte it tests the bit that the opcode's top three bits name. At the end it presents the resulting program counter, a taken indicator and a one-cycle done pulse.

The read port is driven one request per cycle, with `mem_rd_o` and `mem_addr_o`. The memory returns `mem_rdata_i` in the same cycle as the request, as a registered-address RAM does when it is addressed from the sequencer's state registers. The instruction length in cycles is fixed. The not-taken path always takes five cycles and the taken path always takes seven, whatever the operand values. No processor status flag is touched, so the block has no flag ports.

Top module: `membit_branch_seq`

## Requirements
- R1: Counting the cycle after the start edge as cycle 1, reads occur in cycles 1 to 4 only, at addresses PC, PC+1, the page byte (R3), then PC+2. PC+1 carries the page index and PC+2 carries the displacement.
- R2: The tested bit number is opcode bits [7:5]. Opcodes 0x03, 0x23, 0x43, 0x63, 0x83, 0xA3, 0xC3 and 0xE3 test bits 0 to 7. The other seven bits of the page byte do not affect the outcome.
- R3: The page byte address is {7'b0, P, index}. P is the value of `dpage_sel_i` sampled with the start pulse, and later changes of P have no effect on the instruction.
- R4: The branch is taken, with `taken_o` = 1 at done, exactly when the tested bit is 1. Otherwise `taken_o` = 0 at done.
- R5: When not taken, `done_o` is high in cycle 5 and `pc_o` = PC+3 (16-bit wrap).
- R6: When taken, `done_o` is high in cycle 7, with no reads in cycles 5 to 7. `pc_o` = PC+3 plus the sign-extended displacement, modulo 2^16.
- R7: `done_o` is a one-cycle pulse. `pc_o` and `taken_o` change only in a done cycle and hold between done cycles.
- R8: A start pulse that arrives while an instruction is in progress (cycles 1 to 4, or 1 to 6 when taken) is ignored, with no extra reads and no change of timing. A start pulse in the done cycle is accepted.
- R9: Synchronous reset returns the block to idle. After reset `done_o` = 0, `taken_o` = 0, `pc_o` = 0 and `mem_rd_o` = 0, and an instruction cut short by reset produces no further reads and no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| start_pc_i | input | 16 | Address of the instruction's opcode byte |
| dpage_sel_i | input | 1 | Direct-page select, sampled with start |
| mem_rd_o | output | 1 | Read request for this cycle |
| mem_addr_o | output | 16 | Read address |
| mem_rdata_i | input | 8 | Read data returned in the request cycle |
| pc_o | output | 16 | Program counter after the instruction |
| taken_o | output | 1 | Branch taken, valid from the done cycle |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The done pulse of one instruction and the acceptance of the next start can fall in the same cycle. The bench provokes this by raising start in the fifth cycle of a not-taken instruction. It then requires the following instruction's opcode fetch in the very next cycle, with both done pulses at their computed cycles. A start raised in the middle of an instruction, including during the taken path's internal cycles, is judged by the reference read queue: any read beyond those expected is flagged, and the done cycle must not move. The per-cycle model also holds `pc_o` and `taken_o` steady outside done cycles, and after a mid-instruction reset it expects silence.

// File: rtl/mbr_pkg.sv
`timescale 1ns/1ps
package mbr_pkg;
  localparam int INSN_LEN = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_IDX,
    ST_PAGE,
    ST_DISP,
    ST_GAP1,
    ST_GAP2
  } mbr_state_e;
endpackage

// File: rtl/mbr_fsm.sv
`timescale 1ns/1ps
module mbr_fsm
  import mbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       bit_set_i,
  output mbr_state_e state_o
);
  mbr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_OPC;
      ST_OPC:  state_d = ST_IDX;
      ST_IDX:  state_d = ST_PAGE;
      ST_PAGE: state_d = ST_DISP;
      ST_DISP: state_d = bit_set_i ? ST_GAP1 : ST_IDLE;
      ST_GAP1: state_d = ST_GAP2;
      ST_GAP2: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/mbr_bit_sel.sv
`timescale 1ns/1ps
module mbr_bit_sel #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              hit_o
);
  logic [DATA_W-1:0] lane;

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign lane[i] = data_i[i] & (idx_i == IDX_W'(i));
  end

  assign hit_o = |lane;
endmodule

// File: rtl/mbr_target.sv
`timescale 1ns/1ps
module mbr_target #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int INSN_LEN = 3
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DATA_W-1:0] disp_i,
  output logic [ADDR_W-1:0] seq_o,
  output logic [ADDR_W-1:0] br_o
);
  localparam int EXT_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] disp_ext;

  assign disp_ext = {{EXT_W{disp_i[DATA_W-1]}}, disp_i};
  assign seq_o    = base_i + ADDR_W'(INSN_LEN);
  assign br_o     = seq_o + disp_ext;
endmodule

// File: rtl/membit_branch_seq.sv
`timescale 1ns/1ps
module membit_branch_seq
  import mbr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_pc_i,
  input  logic              dpage_sel_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              taken_o,
  output logic              done_o
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int PAD_W = ADDR_W - DATA_W - 1;

  mbr_state_e        state;
  logic [ADDR_W-1:0] pc_q;
  logic              page_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] dp_q;
  logic [DATA_W-1:0] disp_q;
  logic              bit_q;
  logic [ADDR_W-1:0] tgt_q;
  logic              bit_hit;
  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] br_pc;
  logic [ADDR_W-1:0] page_addr;
  logic              busy_w;

  mbr_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .bit_set_i (bit_q),
    .state_o   (state)
  );

  mbr_bit_sel #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bit_sel (
    .idx_i  (idx_q),
    .data_i (mem_rdata_i),
    .hit_o  (bit_hit)
  );

  mbr_target #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INSN_LEN(INSN_LEN)) u_target (
    .base_i (pc_q),
    .disp_i (disp_q),
    .seq_o  (seq_pc),
    .br_o   (br_pc)
  );

  assign busy_w    = (state != ST_IDLE);
  assign page_addr = {{PAD_W{1'b0}}, page_q, dp_q};

  always_comb begin
    mem_rd_o   = 1'b0;
    mem_addr_o = '0;
    unique case (state)
      ST_OPC:  begin mem_rd_o = 1'b1; mem_addr_o = pc_q;                 end
      ST_IDX:  begin mem_rd_o = 1'b1; mem_addr_o = pc_q + ADDR_W'(1);    end
      ST_PAGE: begin mem_rd_o = 1'b1; mem_addr_o = page_addr;            end
      ST_DISP: begin mem_rd_o = 1'b1; mem_addr_o = pc_q + ADDR_W'(2);    end
      default: begin mem_rd_o = 1'b0; mem_addr_o = '0;                   end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      page_q  <= 1'b0;
      idx_q   <= '0;
      dp_q    <= '0;
      disp_q  <= '0;
      bit_q   <= 1'b0;
      tgt_q   <= '0;
      pc_o    <= '0;
      taken_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE: if (start_i) begin
          pc_q   <= start_pc_i;
          page_q <= dpage_sel_i;
        end
        ST_OPC:  idx_q <= mem_rdata_i[DATA_W-1 -: IDX_W];
        ST_IDX:  dp_q  <= mem_rdata_i;
        ST_PAGE: bit_q <= bit_hit;
        ST_DISP: begin
          disp_q <= mem_rdata_i;
          if (!bit_q) begin
            done_o  <= 1'b1;
            taken_o <= 1'b0;
            pc_o    <= seq_pc;
          end
        end
        ST_GAP1: tgt_q <= br_pc;
        ST_GAP2: begin
          done_o  <= 1'b1;
          taken_o <= 1'b1;
          pc_o    <= tgt_q;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/membit_branch_seq_chk.sv
`timescale 1ns/1ps
module membit_branch_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [ADDR_W-1:0] start_pc_i,
  input logic              busy,
  input logic              mem_rd_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic              taken_o,
  input logic              done_o
);
  // R1: an accepted start fetches the opcode at the given address next cycle
  a_r1_first_fetch: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy) |=> (mem_rd_o && mem_addr_o == $past(start_pc_i)));

  // R5: the not-taken done follows directly on the displacement read
  a_r5_fallthrough_gap: assert property (@(posedge clk) disable iff (rst)
    (done_o && !taken_o) |-> $past(mem_rd_o));

  // R6: taken done follows two read-free internal cycles
  a_r6_taken_gap: assert property (@(posedge clk) disable iff (rst)
    (done_o && taken_o) |-> (!$past(mem_rd_o) && !$past(mem_rd_o, 2) && $past(mem_rd_o, 3)));

  // R7: done lasts one cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7: results move only in a done cycle
  a_r7_pc_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(pc_o)) |-> done_o);

  a_r7_taken_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(taken_o)) |-> done_o);

  // R9: the cycle after reset is idle and quiet
  a_r9_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (!mem_rd_o && !done_o && !taken_o && pc_o == '0));
endmodule

bind membit_branch_seq membit_branch_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .start_pc_i (start_pc_i),
  .busy       (busy_w),
  .mem_rd_o   (mem_rd_o),
  .mem_addr_o (mem_addr_o),
  .pc_o       (pc_o),
  .taken_o    (taken_o),
  .done_o     (done_o)
);

// File: tb/membit_branch_seq_tb.sv
`timescale 1ns/1ps
module membit_branch_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] start_pc = '0;
  logic        dpsel = 1'b0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [15:0] pc;
  logic        taken;
  logic        done;

  logic [7:0] mem [0:4095];
  assign mem_rdata = mem[mem_addr[11:0]];

  always #2.5 clk = ~clk;

  membit_branch_seq u_dut (
    .clk (clk), .rst (rst), .start_i (start), .start_pc_i (start_pc),
    .dpage_sel_i (dpsel), .mem_rd_o (mem_rd), .mem_addr_o (mem_addr),
    .mem_rdata_i (mem_rdata), .pc_o (pc), .taken_o (taken), .done_o (done)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit started = 0;
  bit rst_q = 0;
  bit reported = 0;
  logic [15:0] last_pc = '0;

  int          dq_cyc[$];
  logic [15:0] dq_pc[$];
  bit          dq_tk[$];
  logic [15:0] rq_addr[$];
  string       rq_tag[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    mem[a[11:0]] = d;
  endtask

  always @(posedge clk) begin
    started <= 1'b1;
    rst_q   <= rst;
  end

  // per-cycle reference comparison
  always @(negedge clk) begin
    bit exp_done;
    cyc = cyc + 1;
    if (started) begin
      if (rst_q) begin
        chk(done === 1'b0 && taken === 1'b0 && mem_rd === 1'b0 && pc === 16'h0,
            "R9 reset state", {done, taken, mem_rd, pc}, 32'h0);
        last_pc = 16'h0;
      end else begin
        exp_done = (dq_cyc.size() > 0) && (dq_cyc[0] == cyc);
        if (exp_done) begin
          chk(done === 1'b1, dq_tk[0] ? "R6 taken done cycle" : "R5 fallthrough done cycle", done, 1);
          chk(pc === dq_pc[0], dq_tk[0] ? "R6 taken target" : "R5 fallthrough pc", pc, dq_pc[0]);
          chk(taken === dq_tk[0], "R2 R4 taken flag", taken, dq_tk[0]);
          void'(dq_cyc.pop_front());
          void'(dq_pc.pop_front());
          void'(dq_tk.pop_front());
        end else begin
          chk(done === 1'b0, "R7 done pulse outside final cycle", done, 0);
          chk(pc === last_pc, "R7 pc hold", pc, last_pc);
        end
        last_pc = pc;
        if (mem_rd === 1'b1) begin
          if (rq_addr.size() == 0) begin
            chk(1'b0, "R8 unexpected read", mem_addr, 0);
          end else begin
            chk(mem_addr === rq_addr[0], rq_tag[0], mem_addr, rq_addr[0]);
            void'(rq_addr.pop_front());
            void'(rq_tag.pop_front());
          end
        end else if (mem_rd !== 1'b0) begin
          chk(1'b0, "R1 read strobe unknown", mem_rd, 0);
        end
      end
    end
  end

  task automatic launch(input logic [15:0] ipc, input int b, input bit p,
                        input logic [7:0] dp, input bit bv, input logic [7:0] disp);
    logic [7:0]  sel;
    logic [7:0]  pb;
    logic [15:0] tgt;
    int c;
    sel = 8'h01 << b;
    pb  = bv ? sel : ~sel;
    wr(ipc, {3'(b), 5'b00011});
    wr(ipc + 16'd1, dp);
    wr(ipc + 16'd2, disp);
    wr({7'b0, p, dp}, pb);
    wr({7'b0, ~p, dp}, ~pb);
    @(posedge clk); #1;
    start = 1'b1; start_pc = ipc; dpsel = p;
    c = cyc;
    tgt = ipc + 16'd3;
    if (bv) tgt = tgt + {{8{disp[7]}}, disp};
    dq_cyc.push_back(c + 1 + (bv ? 7 : 5));
    dq_pc.push_back(tgt);
    dq_tk.push_back(bv);
    rq_addr.push_back(ipc);               rq_tag.push_back("R1 opcode fetch");
    rq_addr.push_back(ipc + 16'd1);       rq_tag.push_back("R1 index fetch");
    rq_addr.push_back({7'b0, p, dp});     rq_tag.push_back("R3 page byte read");
    rq_addr.push_back(ipc + 16'd2);       rq_tag.push_back("R1 displacement fetch");
    @(posedge clk); #1;
    start = 1'b0; start_pc = 16'hDEAD; dpsel = ~p;
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(posedge clk);
  endtask

  task automatic drain();
    while (dq_cyc.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (3) @(posedge clk);

    // sweep every bit number, both bit values, both pages
    for (int k = 0; k < 32; k++) begin
      launch(16'h0800 + 16'(k * 8), k % 8, k[3], 8'h20 + 8'(k), k[4] ^ k[0],
             k[1] ? (8'h80 + 8'(k)) : (8'h05 + 8'(k)));
      drain();
    end

    // R6 target wraps past the top of the address space
    launch(16'hFFF0, 5, 1'b0, 8'h70, 1'b1, 8'h7F);
    drain();
    // R6 negative displacement wraps below zero
    launch(16'h0002, 3, 1'b1, 8'h71, 1'b1, 8'h80);
    drain();
    // R5 fall-through wraps past the top
    launch(16'hFFFE, 6, 1'b1, 8'h72, 1'b0, 8'h10);
    drain();

    // R8 start in the done cycle of a not-taken instruction is accepted
    launch(16'h0A00, 2, 1'b0, 8'h60, 1'b0, 8'h22);
    wait_cyc(dq_cyc[0] - 2);
    launch(16'h0A10, 4, 1'b1, 8'h61, 1'b1, 8'hF0);
    drain();

    // R8 start mid-instruction is ignored (not-taken and taken paths)
    launch(16'h0B00, 1, 1'b1, 8'h62, 1'b0, 8'h33);
    @(posedge clk); #1; start = 1'b1; start_pc = 16'h0C00;
    @(posedge clk); #1; start = 1'b0;
    drain();
    launch(16'h0B20, 7, 1'b0, 8'h63, 1'b1, 8'hC0);
    repeat (4) @(posedge clk);
    #1; start = 1'b1; start_pc = 16'h0C40;
    @(posedge clk); #1; start = 1'b0;
    drain();

    // R9 reset in the middle of an instruction
    wr(16'h0D00, 8'h03); wr(16'h0D01, 8'h64); wr(16'h0D02, 8'h01);
    @(posedge clk); #1; start = 1'b1; start_pc = 16'h0D00; dpsel = 1'b0;
    rq_addr.push_back(16'h0D00); rq_tag.push_back("R9 fetch before reset");
    rq_addr.push_back(16'h0D01); rq_tag.push_back("R9 fetch before reset");
    @(posedge clk); #1; start = 1'b0;
    @(posedge clk); #1; rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    repeat (10) @(posedge clk);
    chk(rq_addr.size() == 0, "R1 all expected reads seen", rq_addr.size(), 0);

    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired (R5 R6 completion)");
    summary();
    $finish;
  end
endmodule